// File: doc/BRIEF.md
# Speculation-safe load permission gate

This block sits on a load path between the address-translation step and the data cache. Each load arrives with a virtual address, the current privilege mode, a flat-addressing flag and a small in-flight tag. In the same cycle the gate does three things at once. It searches a small fully associative page table, reads that entry's supervisor-only bit alongside the physical page, and compares the bit against the caller's privilege. Only a load that passes the check sends a read to memory in that same cycle, so the check adds no latency.

When a user-mode load touches a supervisor-only page, the gate sends no read at all, speculative or not. It answers with an all-zero word marked as poisoned, so no protected data can reach later speculative work. The gate records the violation against the load's tag. An access fault appears only if the core later retires that tag, which means the load was on the real path.

A lookup that finds no entry reports a miss and also sends no read. Software refills the table through a write port. In flat mode the table and the check are bypassed, and the physical address equals the virtual address.

Top module: `sldg_top`

## Requirements
- R1: For a non-flat load whose page matches a valid entry, and which is not a violation, `mem_rd_valid` is 1 in the same cycle as `req_valid`. `mem_rd_paddr` is the entry's physical page number concatenated with the low 12 address bits.
- R2: When several valid entries hold the same virtual page number, the entry with the lowest index supplies the translation and the supervisor bit.
- R3: A non-flat load with `req_priv_sup`=0 that hits an entry with supervisor bit 1 is a violation, and `mem_rd_valid` stays 0 in that cycle.
- R4: The response to a violation has `rsp_data` all zeros and `rsp_poison`=1. A response to a permitted load has `rsp_poison`=0, and `rsp_data` equals `mem_rd_data` in the response cycle.
- R5: A load with `req_priv_sup`=1 may read a supervisor page. A page with supervisor bit 0 may be read in either mode.
- R6: A load with `req_flat`=1 always reads, with `mem_rd_paddr` equal to `req_vaddr`. It never misses and never violates, even when the table is empty or the page is supervisor-only.
- R7: A non-flat load that matches no valid entry gives `rsp_miss`=1, `rsp_poison`=0 and `rsp_data`=0, and `mem_rd_valid` stays 0.
- R8: Every load gets exactly one response one clock after it is presented, with `rsp_valid`=1 and `rsp_tag` equal to the request's tag. With no request there is no response.
- R9: `flt_valid` pulses one clock after `ret_valid`, with `flt_tag` equal to `ret_tag`, if and only if the most recent load with that tag was a violation. A violating load that is never retired raises no fault. A later load with the same tag replaces the earlier record.
- R10: Reset clears all table entries to invalid. A table write, with `wr_vld` giving the new valid bit, affects lookups from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request present |
| req_vaddr | input | 32 | Load virtual address |
| req_priv_sup | input | 1 | 1 = core in supervisor mode |
| req_flat | input | 1 | 1 = flat addressing, no translation or check |
| req_tag | input | 2 | In-flight tag of the load |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_paddr | output | 32 | Physical read address |
| mem_rd_data | input | 32 | Read data, valid the cycle after the request |
| rsp_valid | output | 1 | Load response present |
| rsp_tag | output | 2 | Tag of the responding load |
| rsp_data | output | 32 | Load data, or zero when blocked |
| rsp_poison | output | 1 | Data is a substitute due to a privilege violation |
| rsp_miss | output | 1 | Translation miss |
| ret_valid | input | 1 | A load is retiring |
| ret_tag | input | 2 | Tag of the retiring load |
| flt_valid | output | 1 | Access fault for a retired violating load |
| flt_tag | output | 2 | Tag of the faulting load |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | 3 | Entry to write |
| wr_vpn | input | 20 | Virtual page number |
| wr_ppn | input | 20 | Physical page number |
| wr_sup | input | 1 | Supervisor-only bit |
| wr_vld | input | 1 | Valid bit |

## Verification
A wrong entry field or a wrong priority choice shows in the same cycle as the load. It appears as a wrong or missing `mem_rd_paddr`, or as a read that should have been suppressed. One clock later it also shows as a wrong miss, poison or data value on the response. A corrupted pending-fault bit is silent until its tag retires. The bench therefore retires violating, clean and overwritten tags, and checks `flt_valid` one clock after each retirement.

// File: rtl/sldg_pkg.sv
package sldg_pkg;
    parameter int DEF_VA_W    = 32;
    parameter int DEF_PAGE_W  = 12;
    parameter int DEF_DATA_W  = 32;
    parameter int DEF_ENTRIES = 8;
    parameter int DEF_TAG_W   = 2;

    typedef enum logic [2:0] {
        LD_IDLE = 3'd0,
        LD_OK   = 3'd1,
        LD_FLAT = 3'd2,
        LD_MISS = 3'd3,
        LD_VIOL = 3'd4
    } ld_kind_e;

    function automatic logic kind_reads(ld_kind_e k);
        return (k == LD_OK) || (k == LD_FLAT);
    endfunction
endpackage

// File: rtl/sldg_xlate_tbl.sv
module sldg_xlate_tbl #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    output logic             lk_sup,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn,
    input  logic             wr_sup,
    input  logic             wr_vld
);
    logic [ENTRIES-1:0] ent_vld;
    logic [ENTRIES-1:0] ent_sup;
    logic [VPN_W-1:0]   ent_vpn [ENTRIES];
    logic [PPN_W-1:0]   ent_ppn [ENTRIES];
    logic [ENTRIES-1:0] match;

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_vld <= '0;
        end else if (wr_en) begin
            ent_vld[wr_idx] <= wr_vld;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            ent_sup[wr_idx] <= wr_sup;
            ent_vpn[wr_idx] <= wr_vpn;
            ent_ppn[wr_idx] <= wr_ppn;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = ent_vld[g] && (ent_vpn[g] == lk_vpn);
    end

    // Walk from the top so the lowest matching index is the last to land.
    always_comb begin
        lk_hit = 1'b0;
        lk_ppn = '0;
        lk_sup = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                lk_hit = 1'b1;
                lk_ppn = ent_ppn[i];
                lk_sup = ent_sup[i];
            end
        end
    end
endmodule

// File: rtl/sldg_perm.sv
module sldg_perm
    import sldg_pkg::*;
(
    input  logic     req_valid,
    input  logic     req_flat,
    input  logic     req_priv_sup,
    input  logic     lk_hit,
    input  logic     lk_sup,
    output ld_kind_e kind,
    output logic     rd_en
);
    always_comb begin
        if (!req_valid)                  kind = LD_IDLE;
        else if (req_flat)               kind = LD_FLAT;
        else if (!lk_hit)                kind = LD_MISS;
        else if (lk_sup && !req_priv_sup) kind = LD_VIOL;
        else                             kind = LD_OK;
    end

    assign rd_en = kind_reads(kind);
endmodule

// File: rtl/sldg_fault_trk.sv
module sldg_fault_trk #(
    parameter int TAG_W = 2,
    localparam int NTAG = 1 << TAG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rec_en,
    input  logic [TAG_W-1:0] rec_tag,
    input  logic             rec_viol,
    input  logic             ret_valid,
    input  logic [TAG_W-1:0] ret_tag,
    output logic             flt_valid,
    output logic [TAG_W-1:0] flt_tag
);
    logic [NTAG-1:0] pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= '0;
            flt_valid <= 1'b0;
            flt_tag   <= '0;
        end else begin
            if (rec_en) pend[rec_tag] <= rec_viol;
            flt_valid <= ret_valid && pend[ret_tag];
            flt_tag   <= ret_tag;
        end
    end
endmodule

// File: rtl/sldg_top.sv
module sldg_top
    import sldg_pkg::*;
#(
    parameter int VA_W    = DEF_VA_W,
    parameter int PAGE_W  = DEF_PAGE_W,
    parameter int DATA_W  = DEF_DATA_W,
    parameter int ENTRIES = DEF_ENTRIES,
    parameter int TAG_W   = DEF_TAG_W,
    localparam int VPN_W  = VA_W - PAGE_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_priv_sup,
    input  logic              req_flat,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              mem_rd_valid,
    output logic [VA_W-1:0]   mem_rd_paddr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              rsp_valid,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_poison,
    output logic              rsp_miss,
    input  logic              ret_valid,
    input  logic [TAG_W-1:0]  ret_tag,
    output logic              flt_valid,
    output logic [TAG_W-1:0]  flt_tag,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [VPN_W-1:0]  wr_ppn,
    input  logic              wr_sup,
    input  logic              wr_vld
);
    logic             lk_hit;
    logic [VPN_W-1:0] lk_ppn;
    logic             lk_sup;
    ld_kind_e         kind;
    logic             rd_en;
    ld_kind_e         kind_q;
    logic [TAG_W-1:0] tag_q;

    sldg_xlate_tbl #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(VPN_W)) tbl_i (
        .clk(clk), .rst(rst),
        .lk_vpn(req_vaddr[VA_W-1:PAGE_W]),
        .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_sup(lk_sup),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn),
        .wr_ppn(wr_ppn), .wr_sup(wr_sup), .wr_vld(wr_vld)
    );

    sldg_perm perm_i (
        .req_valid(req_valid), .req_flat(req_flat), .req_priv_sup(req_priv_sup),
        .lk_hit(lk_hit), .lk_sup(lk_sup), .kind(kind), .rd_en(rd_en)
    );

    sldg_fault_trk #(.TAG_W(TAG_W)) flt_i (
        .clk(clk), .rst(rst),
        .rec_en(req_valid), .rec_tag(req_tag), .rec_viol(kind == LD_VIOL),
        .ret_valid(ret_valid), .ret_tag(ret_tag),
        .flt_valid(flt_valid), .flt_tag(flt_tag)
    );

    assign mem_rd_valid = rd_en;
    assign mem_rd_paddr = req_flat ? req_vaddr : {lk_ppn, req_vaddr[PAGE_W-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= LD_IDLE;
            tag_q  <= '0;
        end else begin
            kind_q <= kind;
            tag_q  <= req_tag;
        end
    end

    assign rsp_valid  = (kind_q != LD_IDLE);
    assign rsp_tag    = tag_q;
    assign rsp_poison = (kind_q == LD_VIOL);
    assign rsp_miss   = (kind_q == LD_MISS);
    assign rsp_data   = kind_reads(kind_q) ? mem_rd_data : '0;
endmodule

// File: rtl/sldg_chk.sv
module sldg_chk #(
    parameter int VA_W    = 32,
    parameter int PAGE_W  = 12,
    parameter int DATA_W  = 32,
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [VA_W-1:0]   req_vaddr,
    input logic              req_flat,
    input logic [TAG_W-1:0]  req_tag,
    input logic              mem_rd_valid,
    input logic [VA_W-1:0]   mem_rd_paddr,
    input logic              rsp_valid,
    input logic [TAG_W-1:0]  rsp_tag,
    input logic [DATA_W-1:0] rsp_data,
    input logic              rsp_poison,
    input logic              rsp_miss,
    input logic              ret_valid,
    input logic [TAG_W-1:0]  ret_tag,
    input logic              flt_valid,
    input logic [TAG_W-1:0]  flt_tag
);
    p_read_needs_req_r1: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |-> req_valid);

    p_viol_no_read_r3: assert property (@(posedge clk) disable iff (rst)
        rsp_poison |-> $past(req_valid && !mem_rd_valid && !req_flat));

    p_poison_zero_r4: assert property (@(posedge clk) disable iff (rst)
        rsp_poison |-> (rsp_data == '0 && !rsp_miss));

    p_flat_pass_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_flat) |-> (mem_rd_valid && mem_rd_paddr == req_vaddr));

    p_miss_no_read_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> ($past(!mem_rd_valid) && rsp_data == '0));

    p_rsp_follows_r8: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (rsp_valid && rsp_tag == $past(req_tag)));

    p_no_spurious_rsp_r8: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    p_flt_after_ret_r9: assert property (@(posedge clk) disable iff (rst)
        flt_valid |-> ($past(ret_valid) && flt_tag == $past(ret_tag)));
endmodule

bind sldg_top sldg_chk #(
    .VA_W(VA_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W), .ENTRIES(ENTRIES), .TAG_W(TAG_W)
) chk_i (.*);

// File: tb/sldg_top_tb_top.sv
`timescale 1ns/1ps
module sldg_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_priv_sup = 1'b0;
    logic        req_flat = 1'b0;
    logic [1:0]  req_tag = '0;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_paddr;
    logic [31:0] mem_rd_data = 32'hDEAD_BEEF;
    logic        rsp_valid;
    logic [1:0]  rsp_tag;
    logic [31:0] rsp_data;
    logic        rsp_poison;
    logic        rsp_miss;
    logic        ret_valid = 1'b0;
    logic [1:0]  ret_tag = '0;
    logic        flt_valid;
    logic [1:0]  flt_tag;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [19:0] wr_vpn = '0;
    logic [19:0] wr_ppn = '0;
    logic        wr_sup = 1'b0;
    logic        wr_vld = 1'b0;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    // Behavioural reference state
    bit          m_vld [8];
    bit          m_sup [8];
    int unsigned m_vpn [8];
    int unsigned m_ppn [8];
    bit          m_pend [4];

    always #2 clk = ~clk;

    // Memory answers one cycle after a read; an unrequested cycle gives a marker.
    always @(posedge clk)
        mem_rd_data <= mem_rd_valid ? (mem_rd_paddr ^ 32'hA5A5_0000) : 32'hDEAD_BEEF;

    sldg_top dut_i (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic ld(input logic [31:0] va, input bit sup, input bit flat,
                      input logic [1:0] tag, input string req);
        int  hit_i = -1;
        bit  exp_rd, exp_miss, exp_viol;
        logic [31:0] exp_pa, exp_dat;
        req_valid = 1; req_vaddr = va; req_priv_sup = sup; req_flat = flat; req_tag = tag;
        for (int i = 7; i >= 0; i--)
            if (m_vld[i] && m_vpn[i] == int'(va[31:12])) hit_i = i;
        exp_miss = !flat && hit_i < 0;
        exp_viol = !flat && hit_i >= 0 && m_sup[hit_i] && !sup;
        exp_rd   = !exp_miss && !exp_viol;
        exp_pa   = flat ? va : (hit_i >= 0 ? {m_ppn[hit_i][19:0], va[11:0]} : 32'h0);
        #1;
        chk(mem_rd_valid == exp_rd, req, "mem_rd_valid", 64'(mem_rd_valid), 64'(exp_rd));
        if (exp_rd)
            chk(mem_rd_paddr == exp_pa, req, "mem_rd_paddr", 64'(mem_rd_paddr), 64'(exp_pa));
        @(posedge clk);
        m_pend[tag] = exp_viol;
        @(negedge clk);
        req_valid = 0;
        exp_dat = exp_rd ? (exp_pa ^ 32'hA5A5_0000) : 32'h0;
        chk(rsp_valid == 1'b1 && rsp_tag == tag, req, "rsp_valid/tag",
            64'({rsp_valid, rsp_tag}), 64'({1'b1, tag}));
        chk(rsp_data == exp_dat, req, "rsp_data", 64'(rsp_data), 64'(exp_dat));
        chk(rsp_poison == exp_viol && rsp_miss == exp_miss, req, "poison/miss",
            64'({rsp_poison, rsp_miss}), 64'({exp_viol, exp_miss}));
    endtask

    task automatic wr(input int idx, input int unsigned vpn, input int unsigned ppn,
                      input bit s, input bit v);
        wr_en = 1; wr_idx = 3'(idx); wr_vpn = 20'(vpn); wr_ppn = 20'(ppn);
        wr_sup = s; wr_vld = v;
        @(negedge clk);
        wr_en = 0;
        m_vld[idx] = v; m_sup[idx] = s; m_vpn[idx] = vpn; m_ppn[idx] = ppn;
    endtask

    task automatic retire(input logic [1:0] tag, input string req);
        bit exp_f;
        ret_valid = 1; ret_tag = tag;
        exp_f = m_pend[tag];
        @(negedge clk);
        ret_valid = 0;
        chk(flt_valid == exp_f, req, "flt_valid", 64'(flt_valid), 64'(exp_f));
        if (exp_f)
            chk(flt_tag == tag, req, "flt_tag", 64'(flt_tag), 64'(tag));
    endtask

    task automatic idle(input string req);
        @(negedge clk);
        chk(rsp_valid == 1'b0, req, "idle rsp_valid", 64'(rsp_valid), 64'd0);
        chk(flt_valid == 1'b0, req, "idle flt_valid", 64'(flt_valid), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_vld[i] = 0; m_sup[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0;
        end
        for (int i = 0; i < 4; i++) m_pend[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // Reset state
        chk(rsp_valid == 0, "R8", "reset rsp_valid", 64'(rsp_valid), 64'd0);
        chk(flt_valid == 0, "R9", "reset flt_valid", 64'(flt_valid), 64'd0);
        chk(mem_rd_valid == 0, "R1", "reset mem_rd_valid", 64'(mem_rd_valid), 64'd0);
        // Empty table: everything misses, flat mode still reads
        ld(32'h0001_0ABC, 0, 0, 2'd0, "R10");
        ld(32'h0001_0ABC, 1, 0, 2'd1, "R7");
        ld(32'h1234_5678, 0, 1, 2'd2, "R6");
        idle("R8");
        // Fill table, including a duplicate page at indices 2 and 3
        wr(0, 32'h00010, 32'h00200, 0, 1);
        wr(1, 32'h00020, 32'h00300, 1, 1);
        wr(2, 32'h00030, 32'h00400, 0, 1);
        wr(3, 32'h00030, 32'h00500, 1, 1);
        wr(7, 32'hFFFFF, 32'h00001, 0, 1);
        wr(5, 32'h00050, 32'h00600, 1, 1);
        wr(4, 32'h00050, 32'h00700, 0, 1);
        ld(32'h0001_0ABC, 0, 0, 2'd0, "R1");
        ld(32'hFFFF_F004, 0, 0, 2'd3, "R1");
        ld(32'h0002_0010, 1, 0, 2'd0, "R5");
        ld(32'h0001_0FFC, 1, 0, 2'd3, "R5");
        ld(32'h0002_0010, 0, 0, 2'd1, "R3");
        ld(32'h0002_0020, 0, 0, 2'd2, "R4");
        ld(32'h0002_0030, 0, 1, 2'd0, "R6");
        ld(32'h0003_0123, 0, 0, 2'd3, "R2");
        ld(32'h0005_0456, 0, 0, 2'd3, "R2");
        // Fault only on retirement
        retire(2'd1, "R9");
        retire(2'd0, "R9");
        retire(2'd3, "R9");
        // Tag 2 violated but is replaced by a clean load before retiring
        ld(32'h0001_0000, 0, 0, 2'd2, "R9");
        retire(2'd2, "R9");
        // Violating tag retired twice still faults each time
        ld(32'h0002_0000, 0, 0, 2'd1, "R3");
        idle("R9");
        retire(2'd1, "R9");
        // Rewrite entry 1 as a user page, invalidate entry 0
        wr(1, 32'h00020, 32'h00310, 0, 1);
        ld(32'h0002_0044, 0, 0, 2'd0, "R10");
        wr(0, 32'h00010, 32'h00200, 0, 0);
        ld(32'h0001_0044, 0, 0, 2'd1, "R10");
        ld(32'h0001_0048, 0, 1, 2'd2, "R6");
        idle("R8");
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule